// File: doc/BRIEF.md
# FIFO Flag Threshold Offset Register

This block holds the two threshold offsets that a FIFO's programmable flags are compared against. One offset is for almost-empty and one is for almost-full. A master reset loads a default into both offsets. The load-select pin, sampled during that reset, also fixes the load method until the next master reset: serial or parallel. In serial mode the offsets are filled one bit per write-clock edge from a serial input. In parallel mode they are filled in data-bus-wide chunks. Either way, the read side can return the stored offsets over the output bus, one chunk per read-clock edge.

A partial reset moves every load and read-back pointer back to the start. It leaves the stored offsets and the chosen method untouched, so a FIFO can be restarted in mid-operation without programming its thresholds again. The FIFO memory and the flag comparators sit outside this block; they use `ae_ofs_o` and `af_ofs_o`.

Top module: `flag_ofs_prog`

## Requirements
- R1: While `mrst_n_i` is low at a write-clock edge, both offsets become 127 and the mode becomes parallel if `ld_i` is 0. If `ld_i` is 1, both offsets become 1023 and the mode becomes serial. The mode changes at no other time.
- R2: In parallel mode, each write-clock edge with `wen_i` and `ld_i` both high writes `din_i` into the next chunk. Chunk k of an offset covers bits 9k and up, and chunks past the top of the offset are truncated. The order is almost-empty low chunk, almost-empty high chunk, almost-full low chunk, almost-full high chunk, and then it wraps back to the first.
- R3: In parallel mode, `sen_i` and `si_i` have no effect on the offsets.
- R4: In serial mode, each write-clock edge with `sen_i` and `ld_i` both high stores `si_i` into the next bit. It fills almost-empty bit 0 upward, then almost-full bit 0 upward, and then wraps.
- R5: In serial mode, `wen_i` and `din_i` have no effect on the offsets.
- R6: Each read-clock edge with `ren_i` and `ld_i` both high places the next chunk on `dout_o`, in the same order as R2. Bits above the offset width read as 0. This works in both modes.
- R7: `dout_o` holds its value on read-clock edges without `ren_i` and `ld_i` both high. A master reset clears it to 0.
- R8: While `prst_n_i` is low (and `mrst_n_i` is high), the write chunk pointer, the serial bit pointer and the read chunk pointer return to the start. The offsets and the mode are unchanged.
- R9: With `ld_i` low, `wen_i`, `sen_i` and `ren_i` change neither the offsets nor `dout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| mrst_n_i | input | 1 | Master reset, synchronous, active low |
| prst_n_i | input | 1 | Partial reset, synchronous, active low |
| ld_i | input | 1 | Load select; picks the default and the mode during master reset |
| sen_i | input | 1 | Serial load enable |
| si_i | input | 1 | Serial data bit |
| wen_i | input | 1 | Parallel load enable |
| din_i | input | CHUNK_W | Parallel load chunk |
| ren_i | input | 1 | Read-back enable |
| ae_ofs_o | output | OFS_W | Almost-empty offset |
| af_ofs_o | output | OFS_W | Almost-full offset |
| dout_o | output | CHUNK_W | Read-back chunk |

## Verification
The bench targets the wrap of the chunk and bit pointers. A wrong wrap would put the fifth chunk or the 33rd bit into a register that does not exist, or into the wrong offset. It also checks that the top chunk is truncated: bits 16 and up must read back as 0, and a design that got this wrong would leak stale bus bits. A partial reset issued mid-sequence must send the next load to the first chunk without touching the offsets; a design that cleared the offsets would lose programmed thresholds. Loads attempted with the enable for the other mode, or with the load select low, must leave the offsets unchanged, and a design that accepted them would corrupt the thresholds.

// File: rtl/ofs_prog_pkg.sv
// Shared types and helpers for the flag offset programming block.
// Assumes nothing beyond elaboration-time constant arguments.
package ofs_prog_pkg;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } load_mode_e;

    // Number of bus chunks needed to cover one offset.
    function automatic int chunks_per_ofs(input int ofs_w, input int chunk_w);
        return (ofs_w + chunk_w - 1) / chunk_w;
    endfunction

endpackage

// File: rtl/ofs_store.sv
// Write-side storage of both offsets, with the master-reset defaults,
// the serial bit loader and the parallel chunk loader.
// Assumes OFS_W >= 10 so that both defaults fit in an offset.
module ofs_store
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int CHUNK_W = 9,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic               clk,
    input  logic               mrst_n,
    input  logic               prst_n,
    input  logic               ld,
    input  logic               sen,
    input  logic               si,
    input  logic               wen,
    input  logic [CHUNK_W-1:0] din,
    output logic [OFS_W-1:0]   ae_q,
    output logic [OFS_W-1:0]   af_q,
    output load_mode_e         mode_q
);
    localparam int NCH    = chunks_per_ofs(OFS_W, CHUNK_W);
    localparam int NWCH   = 2 * NCH;
    localparam int NBIT   = 2 * OFS_W;
    localparam int CPTR_W = $clog2(NWCH);
    localparam int BPTR_W = $clog2(NBIT);

    logic [CPTR_W-1:0] wch_q;
    logic [BPTR_W-1:0] sbit_q;
    logic [OFS_W-1:0]  ae_d, af_d;
    logic              do_ser, do_par;

    // Decide which loader, if any, acts this edge.
    always_comb begin
        do_ser = (mode_q == MODE_SER) && sen && ld;
        do_par = (mode_q == MODE_PAR) && wen && ld;
    end

    // Compute the offsets after one serial bit or one parallel chunk.
    always_comb begin
        ae_d = ae_q;
        af_d = af_q;
        for (int b = 0; b < OFS_W; b++) begin
            if (do_ser) begin
                if (int'(sbit_q) == b)         ae_d[b] = si;
                if (int'(sbit_q) == OFS_W + b) af_d[b] = si;
            end else if (do_par) begin
                if (int'(wch_q) == b / CHUNK_W)       ae_d[b] = din[b % CHUNK_W];
                if (int'(wch_q) == NCH + b / CHUNK_W) af_d[b] = din[b % CHUNK_W];
            end
        end
    end

    // Registers: reset defaults, pointer restart, loads.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= ld ? MODE_SER : MODE_PAR;
            ae_q   <= ld ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
            af_q   <= ld ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
            wch_q  <= '0;
            sbit_q <= '0;
        end else if (!prst_n) begin
            wch_q  <= '0;
            sbit_q <= '0;
        end else begin
            if (do_ser || do_par) begin
                ae_q <= ae_d;
                af_q <= af_d;
            end
            if (do_ser)
                sbit_q <= (int'(sbit_q) == NBIT - 1) ? '0 : sbit_q + 1'b1;
            if (do_par)
                wch_q <= (int'(wch_q) == NWCH - 1) ? '0 : wch_q + 1'b1;
        end
    end

    // R1: the mode only moves under master reset
    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q));

    // R8: partial reset keeps both offsets
    assert_prst_keeps_R8: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ae_q) && $stable(af_q)));

    // R3: in parallel mode only a parallel load can move the offsets
    assert_par_quiet_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_q == MODE_PAR && !(wen && ld)) |=> ($stable(ae_q) && $stable(af_q)));

    // R5: in serial mode only a serial load can move the offsets
    assert_ser_quiet_R5: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_q == MODE_SER && !(sen && ld)) |=> ($stable(ae_q) && $stable(af_q)));

    // R4: a serial load changes at most one offset bit
    assert_one_bit_R4: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_q == MODE_SER && prst_n) |=>
            ($countones({ae_q ^ $past(ae_q), af_q ^ $past(af_q)}) <= 1));

endmodule

// File: rtl/ofs_readback.sv
// Read-side chunk pointer and output register that return the offsets
// one bus chunk at a time. Assumes the offsets are quiet while read.
module ofs_readback
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int CHUNK_W = 9
) (
    input  logic               clk,
    input  logic               mrst_n,
    input  logic               prst_n,
    input  logic               ld,
    input  logic               ren,
    input  logic [OFS_W-1:0]   ae,
    input  logic [OFS_W-1:0]   af,
    output logic [CHUNK_W-1:0] dout_q
);
    localparam int NCH    = chunks_per_ofs(OFS_W, CHUNK_W);
    localparam int NRCH   = 2 * NCH;
    localparam int CPTR_W = $clog2(NRCH);

    logic [CPTR_W-1:0]  rch_q;
    logic [CHUNK_W-1:0] chunk;
    logic [OFS_W-1:0]   src;
    int                 part;

    // Pick the offset and chunk addressed by the read pointer.
    always_comb begin
        src   = (int'(rch_q) < NCH) ? ae : af;
        part  = int'(rch_q) % NCH;
        chunk = '0;
        for (int j = 0; j < CHUNK_W; j++) begin
            for (int b = 0; b < OFS_W; b++) begin
                if (b == part * CHUNK_W + j) chunk[j] = src[b];
            end
        end
    end

    // Output register and pointer advance.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            rch_q  <= '0;
            dout_q <= '0;
        end else if (!prst_n) begin
            rch_q  <= '0;
        end else if (ren && ld) begin
            dout_q <= chunk;
            rch_q  <= (int'(rch_q) == NRCH - 1) ? '0 : rch_q + 1'b1;
        end
    end

    // R7: output holds without a read-back request
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!mrst_n)
        !(ren && ld) |=> $stable(dout_q));

endmodule

// File: rtl/flag_ofs_prog.sv
// Top of the flag offset programming block: write-side storage and
// read-side read-back. Assumes both resets are synchronous to each
// clock domain and that offsets are not loaded while being read back.
module flag_ofs_prog
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int CHUNK_W = 9
) (
    input  logic               wclk_i,
    input  logic               rclk_i,
    input  logic               mrst_n_i,
    input  logic               prst_n_i,
    input  logic               ld_i,
    input  logic               sen_i,
    input  logic               si_i,
    input  logic               wen_i,
    input  logic [CHUNK_W-1:0] din_i,
    input  logic               ren_i,
    output logic [OFS_W-1:0]   ae_ofs_o,
    output logic [OFS_W-1:0]   af_ofs_o,
    output logic [CHUNK_W-1:0] dout_o
);
    load_mode_e mode;

    ofs_store #(
        .OFS_W  (OFS_W),
        .CHUNK_W(CHUNK_W),
        .DEF_PAR(127),
        .DEF_SER(1023)
    ) u_store (
        .clk   (wclk_i),
        .mrst_n(mrst_n_i),
        .prst_n(prst_n_i),
        .ld    (ld_i),
        .sen   (sen_i),
        .si    (si_i),
        .wen   (wen_i),
        .din   (din_i),
        .ae_q  (ae_ofs_o),
        .af_q  (af_ofs_o),
        .mode_q(mode)
    );

    ofs_readback #(
        .OFS_W  (OFS_W),
        .CHUNK_W(CHUNK_W)
    ) u_rb (
        .clk   (rclk_i),
        .mrst_n(mrst_n_i),
        .prst_n(prst_n_i),
        .ld    (ld_i),
        .ren   (ren_i),
        .ae    (ae_ofs_o),
        .af    (af_ofs_o),
        .dout_q(dout_o)
    );

    // R9: nothing moves with the load select low
    assert_ld_gate_R9: assert property (@(posedge wclk_i) disable iff (!mrst_n_i)
        !ld_i |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

    // R1: mode encoding stays a legal value
    assert_mode_legal_R1: assert property (@(posedge wclk_i) disable iff (!mrst_n_i)
        (mode == MODE_PAR) || (mode == MODE_SER));

endmodule

// File: tb/sim_flag_ofs_prog.sv
module sim_flag_ofs_prog;
    logic       clk = 1'b0;
    logic       mrst_n = 1'b0, prst_n = 1'b1, ld = 1'b0;
    logic       sen = 1'b0, si = 1'b0, wen = 1'b0, ren = 1'b0;
    logic [8:0] din = '0;
    logic [15:0] ae_o, af_o;
    logic [8:0]  dout;

    int errors = 0, checks = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_ae = 16'd127, m_af = 16'd127;
    bit          m_ser = 1'b0;
    int          m_wch = 0, m_sb = 0, m_rch = 0;
    logic [8:0]  m_rd = '0;

    always #5 clk = ~clk;

    flag_ofs_prog u0 (
        .wclk_i(clk), .rclk_i(clk), .mrst_n_i(mrst_n), .prst_n_i(prst_n),
        .ld_i(ld), .sen_i(sen), .si_i(si), .wen_i(wen), .din_i(din),
        .ren_i(ren), .ae_ofs_o(ae_o), .af_ofs_o(af_o), .dout_o(dout)
    );

    // behavioural reference, read side first so it sees pre-edge offsets
    always @(posedge clk) begin
        logic [15:0] src;
        if (!mrst_n) begin
            m_rd = '0; m_rch = 0;
            m_ser = ld;
            m_ae = ld ? 16'd1023 : 16'd127;
            m_af = m_ae;
            m_wch = 0; m_sb = 0;
        end else if (!prst_n) begin
            m_rch = 0; m_wch = 0; m_sb = 0;
        end else begin
            if (ren && ld) begin
                src = (m_rch < 2) ? m_ae : m_af;
                m_rd = '0;
                for (int j = 0; j < 9; j++)
                    if ((m_rch % 2) * 9 + j < 16) m_rd[j] = src[(m_rch % 2) * 9 + j];
                m_rch = (m_rch + 1) % 4;
            end
            if (m_ser && sen && ld) begin
                if (m_sb < 16) m_ae[m_sb] = si; else m_af[m_sb - 16] = si;
                m_sb = (m_sb + 1) % 32;
            end else if (!m_ser && wen && ld) begin
                for (int j = 0; j < 9; j++) begin
                    int idx;
                    idx = (m_wch % 2) * 9 + j;
                    if (idx < 16) begin
                        if (m_wch < 2) m_ae[idx] = din[j]; else m_af[idx] = din[j];
                    end
                end
                m_wch = (m_wch + 1) % 4;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks += 3;
            if (ae_o !== m_ae) begin
                errors++; $display("FAIL %s ae_ofs act=%0d exp=%0d", cur_req, ae_o, m_ae);
            end
            if (af_o !== m_af) begin
                errors++; $display("FAIL %s af_ofs act=%0d exp=%0d", cur_req, af_o, m_af);
            end
            if (dout !== m_rd) begin
                errors++; $display("FAIL %s dout act=%0h exp=%0h", cur_req, dout, m_rd);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld = 0; sen = 0; wen = 0; ren = 0; prst_n = 1; mrst_n = 1;
        end
    endtask

    task automatic mreset(input bit sel);
        @(negedge clk); mrst_n = 0; ld = sel; sen = 0; wen = 0; ren = 0;
        @(negedge clk); @(negedge clk); mrst_n = 1; ld = 0;
    endtask

    task automatic pwrite(input logic [8:0] d, input bit also_sen);
        @(negedge clk); ld = 1; wen = 1; din = d; sen = also_sen; si = 1; ren = 0;
    endtask

    task automatic swrite(input bit b, input bit also_wen);
        @(negedge clk); ld = 1; sen = 1; si = b; wen = also_wen; din = 9'h1FF; ren = 0;
    endtask

    task automatic rread(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ld = 1; ren = 1; wen = 0; sen = 0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=hung exp=finished");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1"; mreset(0); idle(2);
        cur_req = "R2"; pwrite(9'h1A5, 0); pwrite(9'h0F3, 0); pwrite(9'h155, 0); pwrite(9'h07F, 0);
        pwrite(9'h111, 0); idle(1);
        cur_req = "R3"; pwrite(9'h02C, 1); idle(2);
        @(negedge clk); ld = 1; sen = 1; si = 1; wen = 0; idle(1);
        cur_req = "R6"; rread(5); idle(1);
        cur_req = "R7"; idle(3);
        cur_req = "R9"; @(negedge clk); ld = 0; wen = 1; sen = 1; ren = 1; din = 9'h1FF; idle(1);
        cur_req = "R8"; pwrite(9'h0AA, 0); rread(1);
        @(negedge clk); prst_n = 0; ld = 1; wen = 1; din = 9'h1FF; idle(1);
        pwrite(9'h033, 0); rread(1); idle(1);
        cur_req = "R1"; mreset(1); idle(2);
        cur_req = "R4";
        for (int i = 0; i < 35; i++) swrite(((i * 7) % 3) == 0, 0);
        idle(1);
        cur_req = "R5"; swrite(1, 1); @(negedge clk); ld = 1; wen = 1; sen = 0; din = 9'h155; idle(1);
        cur_req = "R6"; rread(4); idle(1);
        cur_req = "R8"; swrite(0, 0); @(negedge clk); prst_n = 0; idle(1);
        swrite(1, 0); swrite(1, 0); idle(1);
        cur_req = "R1"; mreset(0); idle(1);
        cur_req = "R2";
        for (int i = 0; i < 12; i++) pwrite(9'($urandom), 0);
        cur_req = "R6"; rread(6); idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule